// File: doc/BRIEF.md
# Comma-Aligned Ten-Bit Word Deserializer

This block turns a serial 8b/10b line stream, presented as one bit per clock with a qualifying strobe, into 10-bit received characters. The earliest bit of each character lands in bit 0 of the output word. The block searches every bit position of the stream for the comma pattern. When it finds one, it moves the word boundary so that the comma starts a character, and it raises a comma flag for that one character.

Output characters come in pairs, one pair per recovered-clock period, and each character carries a phase tag. A comma always lands in phase 1, the slot that matches the complementary clock edge. An alignment-enable input turns the comma search on. When it is low, the block keeps the present boundary and holds the comma flag low. A loopback select feeds the receiver from an internal transmit bit stream instead of the line. While loopback is selected, the line transmit output is held at 1.

Top module: `commaDeser`

## Requirements
- R1: A comma is a 10-bit word whose bits 0..6 are 0,0,1,1,1,1,1. Bits 7..9 are don't-care, so `word[6:0] == 7'b1111100`. `commaFlag` is high exactly when the word being presented was taken as a comma.
- R2: `word[0]` holds the earliest received bit of the character and `word[9]` holds the latest.
- R3: With `alignEn` high, a comma is found at any bit offset. The comma's first bit becomes bit 0 of a new word, and the later words follow the new boundary.
- R4: With `alignEn` low, the current word boundary is kept even when a comma arrives at another offset, and `commaFlag` stays low.
- R5: `commaFlag` is high for exactly one cycle, the cycle in which `wordValid` presents the comma word.
- R6: `wordPhase` toggles on each word. A word taken as a comma is always tagged with phase 1.
- R7: With `loopSel` high, the receiver takes its bits from `loopTx`, and `lineTxOut` is 1.
- R8: With `loopSel` low, the receiver takes its bits from `lineRx`, and `lineTxOut` follows `loopTx`.
- R9: Once aligned, `wordValid` pulses for one cycle every ten accepted bits. A bit counts as accepted only when `bitValid` is high.
- R10: After reset, no `wordValid` pulse appears until a comma has been found with `alignEn` high.
- R11: The word, `wordValid`, `commaFlag` and `wordPhase` appear in the cycle after the clock edge that accepts the word's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineRx | input | 1 | Serial bit from the line |
| bitValid | input | 1 | The selected serial bit is accepted this cycle |
| loopTx | input | 1 | Internal transmit serial bit |
| loopSel | input | 1 | 1 = receive from loopTx, line transmit output held at 1 |
| alignEn | input | 1 | 1 = comma search and realignment enabled |
| lineTxOut | output | 1 | Line transmit serial bit |
| word | output | 10 | Received character, bit 0 earliest |
| wordValid | output | 1 | One-cycle pulse when a new word is presented |
| wordPhase | output | 1 | Phase tag of the presented word |
| commaFlag | output | 1 | Presented word was taken as a comma |

## Verification
Realignment and the regular word boundary can fall on the same accepted bit. This happens when a comma arrives already aligned, and also when a comma completes at an offset a few bits before the counter would have closed the current word. The bench sends commas both at the existing boundary and at other offsets, both while locked and while `alignEn` is low. A behavioural bit-queue model predicts every cycle. In each case it checks that exactly one word is emitted, tagged phase 1 and flagged, and that the partial word is dropped.

// File: rtl/commaDeserPkg.sv
package commaDeserPkg;
  // strobes from control to datapath, valid in the cycle they are raised
  typedef struct packed {
    logic shiftEn;   // accept the selected serial bit
    logic emit;      // capture the current window as an output word
    logic realign;   // the window is a comma taken with alignment enabled
  } deserStrobeT;

  localparam logic COMMA_PHASE = 1'b1;
endpackage

// File: rtl/commaDeserPath.sv
module commaDeserPath
  import commaDeserPkg::*;
#(
  parameter int WORD_W = 10,
  parameter int MARK_W = 7,
  parameter logic [MARK_W-1:0] MARK_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineRx,
  input  logic              loopTx,
  input  logic              loopSel,
  input  deserStrobeT       strobe,
  output logic              commaHit,
  output logic              lineTxOut,
  output logic [WORD_W-1:0] word,
  output logic              commaFlag
);
  logic              selBit;
  logic [WORD_W-1:0] hist;
  logic [WORD_W-1:0] window;

  assign selBit    = loopSel ? loopTx : lineRx;
  assign lineTxOut = loopSel ? 1'b1 : loopTx;

  // newest bit enters at the top; the lowest index is the earliest bit
  assign window   = {selBit, hist[WORD_W-1:1]};
  assign commaHit = (window[MARK_W-1:0] == MARK_PAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist      <= '0;
      word      <= '0;
      commaFlag <= 1'b0;
    end else begin
      commaFlag <= strobe.realign;
      if (strobe.shiftEn) hist <= window;
      if (strobe.emit)    word <= window;
    end
  end
endmodule

// File: rtl/commaDeserCtrl.sv
module commaDeserCtrl
  import commaDeserPkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        alignEn,
  input  logic        commaHit,
  output deserStrobeT strobe,
  output logic        wordValid,
  output logic        wordPhase
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             locked;

  always_comb begin
    strobe.shiftEn = bitValid;
    strobe.realign = bitValid && alignEn && commaHit;
    strobe.emit    = strobe.realign || (bitValid && locked && bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      locked    <= 1'b0;
      wordValid <= 1'b0;
      wordPhase <= 1'b0;
    end else begin
      wordValid <= strobe.emit;
      if (strobe.realign) begin
        locked    <= 1'b1;
        bitCnt    <= '0;
        wordPhase <= COMMA_PHASE;
      end else if (strobe.emit) begin
        bitCnt    <= '0;
        wordPhase <= ~wordPhase;
      end else if (bitValid) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/commaDeser.sv
module commaDeser
  import commaDeserPkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineRx,
  input  logic              bitValid,
  input  logic              loopTx,
  input  logic              loopSel,
  input  logic              alignEn,
  output logic              lineTxOut,
  output logic [WORD_W-1:0] word,
  output logic              wordValid,
  output logic              wordPhase,
  output logic              commaFlag
);
  deserStrobeT strobe;
  logic        commaHit;

  commaDeserCtrl #(.WORD_W(WORD_W)) ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .alignEn(alignEn),
    .commaHit(commaHit), .strobe(strobe), .wordValid(wordValid),
    .wordPhase(wordPhase)
  );

  commaDeserPath #(.WORD_W(WORD_W)) path (
    .clk(clk), .rstN(rstN), .lineRx(lineRx), .loopTx(loopTx),
    .loopSel(loopSel), .strobe(strobe), .commaHit(commaHit),
    .lineTxOut(lineTxOut), .word(word), .commaFlag(commaFlag)
  );
endmodule

// File: rtl/commaDeserChecker.sv
module commaDeserChecker (
  input logic       clk,
  input logic       rstN,
  input logic       alignEn,
  input logic       loopSel,
  input logic       lineTxOut,
  input logic [9:0] word,
  input logic       wordValid,
  input logic       wordPhase,
  input logic       commaFlag
);
  p_comma_content_r1: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> word[6:0] == 7'b1111100);

  p_flag_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> $past(alignEn));

  p_flag_with_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> wordValid);

  p_flag_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |=> !commaFlag);

  p_comma_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> wordPhase);

  p_loop_tx_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    loopSel |-> lineTxOut);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
endmodule

bind commaDeser commaDeserChecker chk (.*);

// File: tb/commaDeser_test.sv
`timescale 1ns/1ps
module commaDeser_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineRx = 1'b0, bitValid = 1'b0, loopTx = 1'b0, loopSel = 1'b0, alignEn = 1'b0;
  logic lineTxOut, wordValid, wordPhase, commaFlag;
  logic [9:0] word;

  always #2.5 clk = ~clk;

  commaDeser uut (.*);

  int checks = 0, fails = 0;
  int hq[$];
  int mCnt = 0;
  bit mLocked = 0, mPhase = 0;
  logic [9:0] eWord = '0;
  logic eValid = 0, eFlag = 0, ePhase = 0;
  int obsValid = 0, obsFlag = 0;
  logic [9:0] lastWord = '0, lastFlagWord = '0;
  logic lastFlagPhase = 0;
  logic [9:0] lfsr = 10'h2B5;
  localparam logic [9:0] COMMA = 10'h17C;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    hq = {};
    for (int i = 0; i < 10; i++) hq.push_back(0);
    mCnt = 0; mLocked = 0; mPhase = 0;
    eWord = '0; eValid = 0; eFlag = 0; ePhase = 0;
  endtask

  task automatic compareOut();
    chk("R9 wordValid", wordValid, eValid);
    chk("R5 commaFlag", commaFlag, eFlag);
    chk("R2 word", word, eWord);
    chk("R6 wordPhase", wordPhase, ePhase);
    if (wordValid) begin
      obsValid++;
      lastWord = word;
    end
    if (commaFlag) begin
      obsFlag++;
      lastFlagWord = word;
      lastFlagPhase = wordPhase;
    end
  endtask

  task automatic modelStep(logic b, logic bv);
    logic sel;
    logic [9:0] w;
    bit hit;
    eValid = 0; eFlag = 0;
    if (!bv) return;
    sel = loopSel ? loopTx : b;
    hq.push_back(int'(sel));
    void'(hq.pop_front());
    for (int i = 0; i < 10; i++) w[i] = hq[i][0];
    hit = alignEn && w[6:0] == 7'b1111100;
    if (hit) begin
      eValid = 1; eFlag = 1; eWord = w; mPhase = 1; ePhase = 1; mLocked = 1; mCnt = 0;
    end else if (mLocked && mCnt == 9) begin
      eValid = 1; eWord = w; mPhase = !mPhase; ePhase = mPhase; mCnt = 0;
    end else mCnt++;
  endtask

  // one clock: check the previous edge, drive the next bit
  task automatic stepBit(logic b, logic bv);
    @(negedge clk);
    compareOut();
    if (loopSel) loopTx = b; else lineRx = b;
    bitValid = bv;
    modelStep(b, bv);
    #1;
    chk(loopSel ? "R7 lineTxOut" : "R8 lineTxOut", lineTxOut, loopSel ? 1 : int'(loopTx));
  endtask

  task automatic sendWord(logic [9:0] w, bit gaps);
    for (int i = 0; i < 10; i++) begin
      if (gaps && lfsr[0]) stepBit(lfsr[3], 1'b0);
      lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
      stepBit(w[i], 1'b1);
    end
  endtask

  task automatic sendJunk(int n);
    for (int i = 0; i < n; i++) stepBit(i[0], 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired, all requirements");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R10 reset wordValid", wordValid, 0);
    chk("R5 reset commaFlag", commaFlag, 0);
    chk("R2 reset word", word, 0);
    rstN = 1'b1;

    // R10: comma with alignEn low, then alternating data with alignEn high
    sendJunk(3); sendWord(COMMA, 0); sendWord(10'h155, 0);
    alignEn = 1'b1;
    sendWord(10'h155, 0); sendWord(10'h2AA, 0);
    stepBit(0, 0);
    chk("R10 no words before lock", obsValid, 0);

    // R1 R3: comma at an odd offset, then aligned words in bit order
    sendJunk(3); sendWord(COMMA, 0);
    stepBit(0, 0); stepBit(0, 0);
    chk("R1 comma flagged once", obsFlag, 1);
    chk("R1 flagged word", lastFlagWord, COMMA);
    chk("R6 comma phase", lastFlagPhase, 1);
    obsValid = 0;
    sendWord(10'h0F0, 0); sendWord(10'h333, 0); sendWord(10'h2C6, 0); sendWord(10'h155, 0);
    stepBit(0, 0);
    chk("R9 four words", obsValid, 4);
    chk("R2 bit order", lastWord, 10'h155);

    // R4: enable low, misaligned comma ignored
    alignEn = 1'b0; obsFlag = 0;
    sendJunk(3); sendWord(COMMA, 0); sendWord(10'h333, 0); sendJunk(7);
    stepBit(0, 0);
    chk("R4 no flag when disabled", obsFlag, 0);

    // R3: re-enable, realign to a new offset, aligned comma next
    alignEn = 1'b1;
    sendJunk(5); sendWord(COMMA, 0); sendWord(10'h155, 0); sendWord(COMMA, 0);
    stepBit(0, 0);
    chk("R3 realigned flags", obsFlag, 2);
    chk("R3 realigned word", lastWord, COMMA);

    // R11: gaps in bitValid
    obsValid = 0;
    sendWord(10'h2C6, 1); sendWord(10'h0F0, 1); sendWord(10'h333, 1);
    stepBit(0, 0);
    chk("R11 words with gaps", obsValid, 3);
    chk("R11 last word with gaps", lastWord, 10'h333);

    // R7: loopback source
    loopSel = 1'b1; obsFlag = 0;
    lineRx = 1'b1;
    sendJunk(4); sendWord(COMMA, 1); sendWord(10'h155, 0);
    stepBit(0, 0);
    chk("R7 loopback comma", obsFlag, 1);
    chk("R7 loopback word", lastWord, 10'h155);

    // R8: back to line input
    loopSel = 1'b0;
    loopTx = 1'b1;
    sendWord(10'h333, 0); sendWord(COMMA, 0);
    stepBit(0, 0);
    chk("R8 line word", lastWord, COMMA);

    @(negedge clk);
    compareOut();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule